// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small nonvolatile word store that a host reaches over a three-wire serial bus. The bus has a select line, a serial clock, a data-in line and a data-out line that the block can release. A port flag says when data-out is being driven. All bus lines are sampled with the block's own system clock, so the serial clock must run several times slower than that clock. The block finds the edges of the serial clock itself.

Each command starts with a '1' bit. A 2-bit opcode and an 8-bit address follow, and write commands then carry a 16-bit word. The block holds 128 words of 16 bits each, so only the low seven address bits pick a word. A read sends one leading zero and then the word. A write is not stored until the host drops select. The block then runs a self-timed store cycle with a fixed count of clocks. While select is high during and after that cycle, data-out shows whether the block is busy or ready. A store replaces the old word directly, with no erase needed first. Writing stays locked after reset until the host sends an unlock command.

Top module: `uwire_eeprom`

## Requirements
- R1: Data-in is sampled on rising serial-clock edges while select is high. A command is a '1' start bit, then opcode bits [1:0], then address bits [7:0], each sent MSB first. A write command then carries 16 data bits, MSB first. Word index = address[6:0].
- R2: Opcode 2'b10 reads. On the rising edge that takes in address bit 0, data-out is driven with a 0. Each later rising edge moves it to the next bit of the addressed word, from bit 15 down to bit 0.
- R3: The data-out enable is low after reset. It is also low whenever select has been low for two system clocks in a row, and at all times outside a read or a status phase.
- R4: Opcode 2'b01 writes. The word is stored when select falls after all 16 data bits have arrived. The store cycle then lasts STORE_CYCLES system clocks, and no serial-clock edges are needed.
- R5: While select is high after a store has started, data-out is driven low while the cycle runs and high once it has finished.
- R6: During a status phase, a '1' sampled on a rising serial-clock edge releases data-out. The enable drops after the next falling serial-clock edge.
- R7: A write replaces the stored word directly; no erase is needed first.
- R8: Writing is locked after reset. While locked, opcodes 2'b01 and 2'b11, erase-all and write-all change nothing and start no store cycle. Opcode 2'b00 with address[7:6]=2'b11 unlocks; opcode 2'b00 with address[7:6]=2'b00 locks again.
- R9: Opcode 2'b11 sets the addressed word to 16'hFFFF. Opcode 2'b00 with address[7:6]=2'b10 sets every word to 16'hFFFF. Opcode 2'b00 with address[7:6]=2'b01 takes in 16 data bits and writes them to every word.
- R10: Command bits sent while a store cycle runs are ignored, and data-out is not driven for them.
- R11: Dropping select before a command is complete aborts it and resets the bit count. An aborted write stores nothing and starts no store cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the block |
| do_o | output | 1 | Serial data out; read data or ready/busy status |
| do_oe | output | 1 | Enable for the data-out line; low means high impedance |

## Verification
The store counter and the status release can act in the same window. The bench starts a store, raises select, and shifts in a '1' while the counter is still running. The enable must stay high while the serial clock is high, be low after the falling edge, and stay low when a full read command is then sent during the busy time. Once the cycle has ended, a read must return the newly stored word. This shows that the release did not cut the store short and that the ignored read did not disturb it.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 8,
  parameter int DEPTH        = 128,
  parameter int STORE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int CNT_W = $clog2(DATA_W + HDR_W + 1);
  localparam int BC_W  = $clog2(STORE_CYCLES + 1);

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_ARMED, S_READ, S_HOLD} st_t;

  st_t               st;
  logic              sk_q;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-2:0]  hdr;
  logic [DATA_W-1:0] wbuf;
  logic [DATA_W:0]   sh;
  logic [IDX_W-1:0]  waddr;
  logic              wall;
  logic              wr_en;
  logic              stat_en;
  logic              rel_pend;
  logic [BC_W-1:0]   bcnt;
  logic [DATA_W-1:0] mem [DEPTH];

  wire sk_rise = sk & ~sk_q;
  wire sk_fall = ~sk & sk_q;
  wire busy    = (bcnt != '0);
  wire store_go = ~cs & (st == S_ARMED);
  wire [HDR_W-1:0] full = {hdr, di};
  wire [1:0] op  = full[HDR_W-1 -: 2];
  wire [1:0] ext = full[ADDR_W-1 -: 2];
  wire [IDX_W-1:0] fidx = full[IDX_W-1:0];

  assign do_oe = (st == S_READ) | (stat_en & cs);
  assign do_o  = (st == S_READ) ? sh[DATA_W] : ~busy;

  always_ff @(posedge clk) begin
    if (store_go) begin
      for (int i = 0; i < DEPTH; i++)
        if (wall || waddr == IDX_W'(i)) mem[i] <= wbuf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sk_q     <= 1'b0;
      cnt      <= '0;
      hdr      <= '0;
      wbuf     <= '0;
      sh       <= '0;
      waddr    <= '0;
      wall     <= 1'b0;
      wr_en    <= 1'b0;
      stat_en  <= 1'b0;
      rel_pend <= 1'b0;
      bcnt     <= '0;
    end else begin
      sk_q <= sk;
      if (busy) bcnt <= bcnt - 1'b1;
      if (!cs) begin
        rel_pend <= 1'b0;
        if (!busy) stat_en <= 1'b0;
        if (st == S_ARMED) begin
          bcnt    <= BC_W'(STORE_CYCLES);
          stat_en <= 1'b1;
        end
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        if (sk_fall && rel_pend) begin
          stat_en  <= 1'b0;
          rel_pend <= 1'b0;
        end
        if (sk_rise) begin
          case (st)
            S_IDLE: begin
              if (di && stat_en) rel_pend <= 1'b1;
              else if (di && !busy) begin
                st  <= S_HDR;
                cnt <= '0;
              end
            end
            S_HDR: begin
              hdr <= full[HDR_W-2:0];
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(HDR_W - 1)) begin
                cnt   <= '0;
                waddr <= fidx;
                wall  <= 1'b0;
                st    <= S_HOLD;
                case (op)
                  OP_READ: begin
                    sh <= {1'b0, mem[fidx]};
                    st <= S_READ;
                  end
                  OP_WRITE: if (wr_en) st <= S_DATA;
                  OP_ERASE: if (wr_en) begin
                    wbuf <= '1;
                    st   <= S_ARMED;
                  end
                  OP_EXT: begin
                    case (ext)
                      2'b11: wr_en <= 1'b1;
                      2'b00: wr_en <= 1'b0;
                      2'b10: if (wr_en) begin
                        wbuf <= '1;
                        wall <= 1'b1;
                        st   <= S_ARMED;
                      end
                      default: if (wr_en) begin
                        wall <= 1'b1;
                        st   <= S_DATA;
                      end
                    endcase
                  end
                  default: ;
                endcase
              end
            end
            S_DATA: begin
              wbuf <= {wbuf[DATA_W-2:0], di};
              cnt  <= cnt + 1'b1;
              if (cnt == CNT_W'(DATA_W - 1)) st <= S_ARMED;
            end
            S_READ: sh <= {sh[DATA_W-1:0], 1'b0};
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sk,
  input logic do_o,
  input logic do_oe,
  input logic busy,
  input logic wr_en
);
  AST_STORE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!cs && $past(!cs))) else $error("store start without deselect"); // R4
  AST_STORE_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_en) else $error("store while locked"); // R8
  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (do_oe && busy) |-> !do_o) else $error("ready shown while busy"); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && $past(!cs)) |-> !do_oe) else $error("driving while deselected"); // R3
  AST_RELEASE_AT_SK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(do_oe) && cs) |-> ($past(sk) == 1'b0 && $past(sk, 2) == 1'b1)) else $error("release off the falling edge"); // R6
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk),
  .do_o(do_o), .do_oe(do_oe), .busy(busy), .wr_en(wr_en)
);

// File: tb/uwire_eeprom_tb.sv
module uwire_eeprom_tb;
  localparam int STORE = 1000;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int n_chk = 0, n_bad = 0;

  uwire_eeprom #(.STORE_CYCLES(STORE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe));

  always #5 clk = ~clk;

  localparam logic [23:0] VEC [6] = '{
    {8'h05, 16'h1234}, {8'h7F, 16'hBEEF}, {8'h00, 16'h8001},
    {8'h05, 16'h5A5A}, {8'h40, 16'h0000}, {8'h85, 16'hC3C3}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o, output logic oe);
    @(negedge clk); di = b;
    repeat (2) @(negedge clk); sk = 1'b1;
    repeat (2) @(negedge clk); o = do_o; oe = do_oe; sk = 1'b0;
  endtask

  task automatic deselect;
    @(negedge clk); cs = 1'b0; di = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [7:0] a, output logic o, output logic oe);
    @(negedge clk); cs = 1'b1;
    bit_io(1'b1, o, oe);
    for (int i = 1; i >= 0; i--) bit_io(op[i], o, oe);
    for (int i = 7; i >= 0; i--) bit_io(a[i], o, oe);
  endtask

  task automatic send_word(input logic [15:0] d);
    logic o, oe;
    for (int i = 15; i >= 0; i--) bit_io(d[i], o, oe);
  endtask

  task automatic do_read(input logic [7:0] a, output logic d0, output logic d0_oe,
                         output logic [15:0] w, output logic any_oe);
    logic o, oe;
    send_hdr(2'b10, a, d0, d0_oe);
    any_oe = d0_oe;
    for (int i = 15; i >= 0; i--) begin
      bit_io(1'b0, o, oe);
      w[i] = o;
      any_oe |= oe;
    end
    deselect();
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] a);
    logic o, oe;
    send_hdr(op, a, o, oe);
    deselect();
  endtask

  task automatic cmd_data(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    logic o, oe;
    send_hdr(op, a, o, oe);
    send_word(d);
    deselect();
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
    chk({req, " status busy oe/do"}, {do_oe, do_o}, 2'b10);
    while (do_o == 1'b0 && n < 5000) begin
      @(negedge clk); n++;
    end
    chk({req, " busy length in range"}, (n >= STORE - 20 && n <= STORE), 1);
    chk({req, " status ready oe/do"}, {do_oe, do_o}, 2'b11);
    deselect();
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic d0, d0oe, aoe;
    logic [15:0] w;
    do_read(a, d0, d0oe, w, aoe);
    chk({req, " read word"}, w, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic d0, d0oe, aoe, o, oe;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    chk("R3 reset oe", do_oe, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 after reset oe", do_oe, 1'b0);

    // R8: locked write is ignored and starts no store
    cmd_data(2'b01, 8'h03, 16'h1111);
    @(negedge clk); cs = 1'b1; @(negedge clk);
    chk("R8 locked write no status", do_oe, 1'b0);
    deselect();
    cmd(2'b00, 8'hC0);              // unlock
    cmd(2'b00, 8'h80);              // erase-all
    wait_ready("R9 erase-all");
    read_chk("R9 erase-all addr 03", 8'h03, 16'hFFFF);

    // R1 R2 R4 R7: table of writes then read-back
    for (int i = 0; i < 6; i++) begin
      cmd_data(2'b01, VEC[i][23:16], VEC[i][15:0]);
      wait_ready("R4 table write");
      do_read(VEC[i][23:16], d0, d0oe, w, aoe);
      chk("R2 dummy zero driven", {d0oe, d0}, 2'b10);
      chk("R1 R7 table readback", w, VEC[i][15:0]);
    end
    // R1: address bit 7 ignored for word index (0x85 hit 0x05)
    read_chk("R1 index from low bits", 8'h05, 16'hC3C3);

    // R2: DO holds between rising edges
    send_hdr(2'b10, 8'h7F, o, oe);
    bit_io(1'b0, o, oe);
    chk("R2 first data bit", o, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R2 stable after fall", {do_oe, do_o}, 2'b11);
    deselect();
    chk("R3 released after deselect", do_oe, 1'b0);

    // R8: lock again, write ignored
    cmd(2'b00, 8'h00);
    cmd_data(2'b01, 8'h00, 16'h7777);
    read_chk("R8 relocked write ignored", 8'h00, 16'h8001);
    cmd(2'b11, 8'h00);
    read_chk("R8 relocked erase ignored", 8'h00, 16'h8001);
    cmd(2'b00, 8'hC0);

    // R11: aborted write stores nothing and starts no store
    send_hdr(2'b01, 8'h30, o, oe);
    for (int i = 0; i < 8; i++) bit_io(1'b1, o, oe);
    deselect();
    @(negedge clk); cs = 1'b1; @(negedge clk);
    chk("R11 abort no status", do_oe, 1'b0);
    deselect();
    read_chk("R11 aborted write", 8'h30, 16'hFFFF);
    // R11: partial header then full read
    @(negedge clk); cs = 1'b1;
    bit_io(1'b1, o, oe); bit_io(1'b1, o, oe); bit_io(1'b0, o, oe);
    deselect();
    read_chk("R11 counter reset", 8'h7F, 16'hBEEF);

    // R9: single erase
    cmd(2'b11, 8'h7F);
    wait_ready("R9 erase");
    read_chk("R9 erase word", 8'h7F, 16'hFFFF);

    // R6 R10: release while store runs, then command ignored
    cmd_data(2'b01, 8'h20, 16'hA5A5);
    @(negedge clk); cs = 1'b1; @(negedge clk);
    chk("R5 busy shown", {do_oe, do_o}, 2'b10);
    @(negedge clk); di = 1'b1;
    repeat (2) @(negedge clk); sk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 held while sk high", do_oe, 1'b1);
    sk = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 released after sk fall", do_oe, 1'b0);
    deselect();
    do_read(8'h05, d0, d0oe, w, aoe);
    chk("R10 read ignored while busy", aoe, 1'b0);
    repeat (STORE + 100) @(negedge clk);
    read_chk("R10 store completed", 8'h20, 16'hA5A5);

    // R9: write-all
    cmd_data(2'b00, 8'h40, 16'h0F0F);
    wait_ready("R9 write-all");
    read_chk("R9 write-all low", 8'h00, 16'h0F0F);
    read_chk("R9 write-all high", 8'h7F, 16'h0F0F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule